// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Four Prescaler

This block is a bus-mapped watchdog. Software picks one of three tick sources and a divide ratio, loads a 16-bit timeout and sets the enable bit. Each prescaled tick then moves a live counter up by one. When the counter reaches the timeout, the block raises a single-cycle reset request and returns the counter to zero. Software keeps the system alive by writing zero into the counter register before the timeout comes round.

The three clock sources arrive as tick-enable strobes in the block's own clock domain. This lets source selection, the prescaler, the counter and the compare all run in one synchronous domain. Software is expected to clear the enable bit before it changes the control or timeout registers.

Top module: `wdog_top`

## Requirements
- R1: After reset, every register reads zero, the block is disabled and `wdog_reset_req` is low.
- R2: The registers are at byte offsets 0x0 (timeout, 16 bits), 0x4 (enable, bit 0 only), 0x8 (live counter, 16 bits) and 0xC (control, bits [5:0]). A write takes effect at the next clock edge. Unused bits read zero. A write to any other address changes nothing, and reads of other addresses return zero.
- R3: Control bits [2:0] are a one-hot source select: bit 0 takes `tick_periph`, bit 1 takes `tick_rtc` and bit 2 takes `tick_ext`. Strobes on sources that are not selected have no effect.
- R4: If control bits [2:0] are zero, or have more than one bit set, the counter does not advance.
- R5: Control bits [5:3] hold a divide code c. For codes 0 to 5, one counter tick is produced per 4^c strobes of the selected source. Codes 6 and 7 divide by 1024.
- R6: The prescaler restarts from zero whenever the enable bit is 0 or the control register is written. The first tick after enabling, or after a control write, therefore needs a full divide period of source strobes.
- R7: While enabled, the counter rises by one on each prescaled tick and wraps from 0xFFFF to 0. While disabled, it holds its value.
- R8: In a cycle where the block is enabled, the counter equals the timeout, and no reset request was raised in the previous cycle, `wdog_reset_req` is high after the next edge. At that same edge the counter becomes zero, and any tick in that cycle is lost.
- R9: A bus write to the counter loads the written value, and writing zero restarts the countdown. This write takes priority over a tick and over a timeout match in the same cycle, and a match in that cycle raises no reset request.
- R10: `wdog_reset_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_periph | input | 1 | Strobe of the peripheral-clock source |
| tick_rtc | input | 1 | Strobe of the real-time-clock source |
| tick_ext | input | 1 | Strobe of the external-clock source |
| wdog_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with its default widths: a 16-bit data path, 4-bit addresses, three sources and a divide code capped at 5. This puts the largest ratio of 1024, and the clamped codes 6 and 7, within a few thousand cycles. Small timeouts of one to five ticks let many timeout events, keep-alive writes landing on a match cycle, and the 0xFFFF wrap all fit inside the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Default geometry of the watchdog
    localparam int WDOG_DATA_W  = 16;
    localparam int WDOG_ADDR_W  = 4;
    localparam int WDOG_SRC_N   = 3;
    localparam int WDOG_DIV_W   = 3;
    localparam int WDOG_DIV_MAX = 5;
    localparam int WDOG_DIV_LOG = 2;

    // Byte offsets of the register slots
    localparam int OFS_TIMEOUT = 'h0;
    localparam int OFS_ENABLE  = 'h4;
    localparam int OFS_COUNT   = 'h8;
    localparam int OFS_CONTROL = 'hC;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = WDOG_DATA_W,
    parameter int ADDR_W = WDOG_ADDR_W,
    parameter int SRC_N  = WDOG_SRC_N,
    parameter int DIV_W  = WDOG_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tmo,
    output logic              en,
    output logic [SRC_N-1:0]  src_sel,
    output logic [DIV_W-1:0]  div_code,
    output logic              ctl_wr,
    output logic              cnt_wr
);

    localparam int CTL_W = SRC_N + DIV_W;

    typedef struct packed {
        logic [DATA_W-1:0] tmo;
        logic              en;
        logic [CTL_W-1:0]  ctl;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic hit_tmo, hit_en, hit_cnt, hit_ctl;

    always_comb begin
        hit_tmo = (bus_addr == ADDR_W'(OFS_TIMEOUT));
        hit_en  = (bus_addr == ADDR_W'(OFS_ENABLE));
        hit_cnt = (bus_addr == ADDR_W'(OFS_COUNT));
        hit_ctl = (bus_addr == ADDR_W'(OFS_CONTROL));

        s_d = s_q;
        if (bus_we && hit_tmo) s_d.tmo = bus_wdata;
        if (bus_we && hit_en)  s_d.en  = bus_wdata[0];
        if (bus_we && hit_ctl) s_d.ctl = bus_wdata[CTL_W-1:0];

        ctl_wr = bus_we && hit_ctl;
        cnt_wr = bus_we && hit_cnt;

        if (hit_tmo)      bus_rdata = s_q.tmo;
        else if (hit_en)  bus_rdata = {{(DATA_W-1){1'b0}}, s_q.en};
        else if (hit_cnt) bus_rdata = cnt_val;
        else if (hit_ctl) bus_rdata = {{(DATA_W-CTL_W){1'b0}}, s_q.ctl};
        else              bus_rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tmo      = s_q.tmo;
    assign en       = s_q.en;
    assign src_sel  = s_q.ctl[SRC_N-1:0];
    assign div_code = s_q.ctl[CTL_W-1:SRC_N];

    // R2: a control write is visible on the decoded fields one edge later
    p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ({div_code, src_sel} == $past(bus_wdata[CTL_W-1:0])));

    // R2: the enable flag follows bit 0 of a write to its slot
    p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_en) |=> (en == $past(bus_wdata[0])));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int SRC_N   = WDOG_SRC_N,
    parameter int DIV_W   = WDOG_DIV_W,
    parameter int DIV_MAX = WDOG_DIV_MAX,
    parameter int DIV_LOG = WDOG_DIV_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ctl_wr,
    input  logic [SRC_N-1:0] src_sel,
    input  logic [DIV_W-1:0] div_code,
    input  logic [SRC_N-1:0] src_tick,
    output logic             tick
);

    localparam int PRE_W = DIV_MAX * DIV_LOG;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [SRC_N-1:0] src_hit;
    logic             src_ok;
    logic [DIV_W-1:0] div_eff;
    logic [PRE_W-1:0] limit;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign src_hit[g] = src_sel[g] & src_tick[g];
    end

    always_comb begin
        src_ok  = $onehot(src_sel) && (|src_hit);
        div_eff = (int'(div_code) > DIV_MAX) ? DIV_W'(DIV_MAX) : div_code;
        for (int k = 0; k < PRE_W; k++) begin
            limit[k] = (k < DIV_LOG * int'(div_eff));
        end

        tick = en && !ctl_wr && src_ok && (s_q.cnt == limit);

        s_d = s_q;
        if (!en || ctl_wr)      s_d.cnt = '0;
        else if (src_ok) begin
            if (s_q.cnt == limit) s_d.cnt = '0;
            else                  s_d.cnt = s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: without exactly one selected source no tick leaves the prescaler
    p_no_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(src_sel) |-> !tick);

    // R6: a disabled block leaves the prescaler at zero for the next period
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0));

    // R5: every emitted tick starts a fresh divide period
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.cnt == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int DATA_W = WDOG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] tmo,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt,
    output logic              rst_req
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              req;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic fire;

    always_comb begin
        fire = en && (s_q.cnt == tmo) && !s_q.req;

        s_d     = s_q;
        s_d.req = fire && !cnt_wr;
        if (cnt_wr)    s_d.cnt = wdata;
        else if (fire) s_d.cnt = '0;
        else if (tick) s_d.cnt = s_q.cnt + DATA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign rst_req = s_q.req;

    // R10: the reset request never lasts more than one cycle
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: a disabled counter holds unless software loads it
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt));

    // R9: a bus load wins over ticks and matches
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

    // R8: a timeout match raises the request and restarts the count
    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cnt == tmo) && !rst_req && !cnt_wr) |=> (rst_req && (cnt == '0)));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int DATA_W  = WDOG_DATA_W,
    parameter int ADDR_W  = WDOG_ADDR_W,
    parameter int DIV_W   = WDOG_DIV_W,
    parameter int DIV_MAX = WDOG_DIV_MAX,
    parameter int DIV_LOG = WDOG_DIV_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_periph,
    input  logic              tick_rtc,
    input  logic              tick_ext,
    output logic              wdog_reset_req
);

    localparam int SRC_N = 3;

    logic [DATA_W-1:0] tmo, cnt;
    logic              en, ctl_wr, cnt_wr, tick;
    logic [SRC_N-1:0]  src_sel, src_tick;
    logic [DIV_W-1:0]  div_code;

    // Source order matches the select bit positions
    assign src_tick = {tick_ext, tick_rtc, tick_periph};

    wdog_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SRC_N  (SRC_N),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt),
        .bus_rdata (bus_rdata),
        .tmo       (tmo),
        .en        (en),
        .src_sel   (src_sel),
        .div_code  (div_code),
        .ctl_wr    (ctl_wr),
        .cnt_wr    (cnt_wr)
    );

    wdog_prescaler #(
        .SRC_N   (SRC_N),
        .DIV_W   (DIV_W),
        .DIV_MAX (DIV_MAX),
        .DIV_LOG (DIV_LOG)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ctl_wr   (ctl_wr),
        .src_sel  (src_sel),
        .div_code (div_code),
        .src_tick (src_tick),
        .tick     (tick)
    );

    wdog_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .tmo     (tmo),
        .cnt_wr  (cnt_wr),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .rst_req (wdog_reset_req)
    );

endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        tp, tr, te;
    logic        rreq;

    always #4 clk = ~clk;   // 8 ns period

    wdog_top u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_we         (we),
        .bus_addr       (addr),
        .bus_wdata      (wdata),
        .bus_rdata      (rdata),
        .tick_periph    (tp),
        .tick_rtc       (tr),
        .tick_ext       (te),
        .wdog_reset_req (rreq)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string phase = "R1";

    // Reference state
    int m_tmo, m_en, m_ctl, m_cnt, m_pre, m_rst;

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0:  return m_tmo;
            4:  return m_en;
            8:  return m_cnt;
            12: return m_ctl;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int sel, code, ratio, n_pre, n_cnt;
        bit go, cw, nw, tk, mt;
        sel   = m_ctl & 7;
        code  = (m_ctl >> 3) & 7;
        if (code > 5) code = 5;
        ratio = 1 << (2 * code);
        go = (sel == 1 && tp) || (sel == 2 && tr) || (sel == 4 && te);
        cw = we && (addr == 4'hC);
        nw = we && (addr == 4'h8);
        tk = (m_en != 0) && !cw && go && (m_pre == ratio - 1);
        mt = (m_en != 0) && (m_cnt == m_tmo) && (m_rst == 0);
        if (m_en == 0 || cw) n_pre = 0;
        else if (go)         n_pre = (m_pre + 1) % ratio;
        else                 n_pre = m_pre;
        if (nw)      n_cnt = int'(wdata);
        else if (mt) n_cnt = 0;
        else if (tk) n_cnt = (m_cnt + 1) & 'hFFFF;
        else         n_cnt = m_cnt;
        m_rst = (mt && !nw) ? 1 : 0;
        m_pre = n_pre;
        m_cnt = n_cnt;
        if (we) begin
            case (addr)
                4'h0: m_tmo = int'(wdata);
                4'h4: m_en  = int'(wdata[0]);
                4'hC: m_ctl = int'(wdata) & 'h3F;
                default: ;
            endcase
        end
    endtask

    // One clock: update reference at the edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({phase, " reset request"}, int'(rreq), m_rst);
        check({phase, " readback"}, int'(rdata), m_read(int'(addr)));
    endtask

    task automatic wr(int a, int d);
        we = 1'b1; addr = a[3:0]; wdata = d[15:0];
        cyc();
        we = 1'b0; addr = 4'h8; wdata = '0;
    endtask

    task automatic idle(int n, bit p, bit r, bit e);
        tp = p; tr = r; te = e;
        repeat (n) cyc();
        tp = 1'b0; tr = 1'b0; te = 1'b0;
    endtask

    task automatic rd(int a, string tag, int exp);
        addr = a[3:0];
        #1;
        check(tag, int'(rdata), exp);
        addr = 4'h8;
    endtask

    task automatic setup(int ctl, int tmo);
        wr(4, 0);
        wr(12, ctl);
        wr(0, tmo);
        wr(8, 0);
        wr(4, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; we = 1'b0; addr = 4'h8; wdata = '0;
        tp = 1'b0; tr = 1'b0; te = 1'b0;
        m_tmo = 0; m_en = 0; m_ctl = 0; m_cnt = 0; m_pre = 0; m_rst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0,  "R1 timeout after reset", 0);
        rd(4,  "R1 enable after reset", 0);
        rd(8,  "R1 counter after reset", 0);
        rd(12, "R1 control after reset", 0);
        check("R1 reset request after reset", int'(rreq), 0);

        // R2: offsets, field widths, unmapped addresses
        phase = "R2";
        wr(0, 'hA5C3);
        rd(0, "R2 timeout readback", 'hA5C3);
        wr(12, 'hFFFF);
        rd(12, "R2 control keeps bits 5:0", 'h3F);
        wr(4, 'hFFFE);
        rd(4, "R2 enable uses bit 0", 0);
        wr(4, 1);
        rd(4, "R2 enable set", 1);
        wr(2, 'hFFFF);
        rd(2, "R2 unmapped reads zero", 0);
        rd(0, "R2 unmapped write leaves timeout", 'hA5C3);
        rd(12, "R2 unmapped write leaves control", 'h3F);
        wr(4, 0);

        // R6: full prescale period after enable and after control write
        phase = "R6";
        setup('h09, 'h100);
        idle(3, 1, 0, 0);
        rd(8, "R6 no tick before a full period", 0);
        idle(1, 1, 0, 0);
        rd(8, "R6 first tick after four strobes", 1);
        idle(2, 1, 0, 0);
        tp = 1'b1;
        wr(12, 'h09);
        tp = 1'b0;
        idle(3, 1, 0, 0);
        rd(8, "R6 control write restarts prescaler", 1);
        idle(1, 1, 0, 0);
        rd(8, "R6 tick after restarted period", 2);

        // R7: freeze while disabled, count while enabled
        phase = "R7";
        wr(4, 0);
        idle(10, 1, 1, 1);
        rd(8, "R7 counter frozen while disabled", 2);
        wr(4, 1);
        idle(8, 1, 0, 0);
        rd(8, "R7 counter resumes", 4);

        // R3: one-hot source routing
        phase = "R3";
        setup('h02, 'h100);
        idle(5, 1, 0, 1);
        rd(8, "R3 unselected sources ignored for rtc", 0);
        idle(3, 0, 1, 0);
        rd(8, "R3 rtc strobes counted", 3);
        setup('h04, 'h100);
        idle(4, 1, 1, 0);
        rd(8, "R3 unselected sources ignored for ext", 0);
        idle(2, 0, 0, 1);
        rd(8, "R3 ext strobes counted", 2);
        setup('h01, 'h100);
        idle(5, 0, 1, 1);
        rd(8, "R3 unselected sources ignored for periph", 0);
        idle(3, 1, 0, 0);
        rd(8, "R3 periph strobes counted", 3);

        // R4: invalid selections
        phase = "R4";
        setup('h03, 'h100);
        idle(6, 1, 1, 1);
        rd(8, "R4 two sources selected", 0);
        setup('h00, 'h100);
        idle(6, 1, 1, 1);
        rd(8, "R4 no source selected", 0);
        setup('h07, 'h100);
        idle(6, 1, 1, 1);
        rd(8, "R4 all sources selected", 0);

        // R8 and R10: timeout pulse
        phase = "R8";
        setup('h01, 2);
        idle(2, 1, 0, 0);
        rd(8, "R8 counter reaches timeout", 2);
        check("R8 no request before match", int'(rreq), 0);
        idle(1, 0, 0, 0);
        check("R8 request after match", int'(rreq), 1);
        rd(8, "R8 counter cleared on timeout", 0);
        idle(1, 0, 0, 0);
        check("R10 request lasts one cycle", int'(rreq), 0);

        // R9: software loads and priority
        phase = "R9";
        wr(8, 'h1234);
        rd(8, "R9 counter load", 'h1234);
        wr(8, 2);
        wr(8, 0);
        check("R9 keep-alive on match cycle suppresses request", int'(rreq), 0);
        rd(8, "R9 keep-alive clears counter", 0);
        tp = 1'b1;
        wr(8, 'h10);
        tp = 1'b0;
        rd(8, "R9 write beats tick", 'h10);
        wr(8, 'hFFFF);
        idle(1, 1, 0, 0);
        rd(8, "R7 counter wraps at 0xFFFF", 0);

        // R5: divide codes at the top of the range
        phase = "R5";
        setup('h39, 'h100);
        idle(1023, 1, 0, 0);
        rd(8, "R5 code 7 no tick before 1024", 0);
        idle(1, 1, 0, 0);
        rd(8, "R5 code 7 divides by 1024", 1);
        setup('h31, 'h100);
        idle(1023, 1, 0, 0);
        rd(8, "R5 code 6 no tick before 1024", 0);
        idle(1, 1, 0, 0);
        rd(8, "R5 code 6 divides by 1024", 1);
        setup('h29, 'h100);
        idle(1023, 1, 0, 0);
        rd(8, "R5 code 5 no tick before 1024", 0);
        idle(1, 1, 0, 0);
        rd(8, "R5 code 5 divides by 1024", 1);

        // Mixed random traffic against the reference, R8 timeouts and R9 keep-alives
        phase = "R8 random";
        for (int c = 0; c < 7; c++) begin
            int ctl_v, tmo_v;
            case (c)
                0: begin ctl_v = 'h01; tmo_v = 5; end
                1: begin ctl_v = 'h0A; tmo_v = 3; end
                2: begin ctl_v = 'h14; tmo_v = 2; end
                3: begin ctl_v = 'h1B; tmo_v = 1; end
                4: begin ctl_v = 'h22; tmo_v = 1; end
                5: begin ctl_v = 'h0C; tmo_v = 4; end
                default: begin ctl_v = 'h11; tmo_v = 3; end
            endcase
            setup(ctl_v, tmo_v);
            for (int i = 0; i < 3000; i++) begin
                tp = 1'($urandom_range(0, 1));
                tr = 1'($urandom_range(0, 1));
                te = 1'($urandom_range(0, 1));
                if ($urandom_range(0, 49) == 0) wr(8, 0);
                else                            cyc();
            end
            tp = 1'b0; tr = 1'b0; te = 1'b0;
        end

        finish_run();
    end

endmodule